// File: doc/BRIEF.md
# Victim-Replicating L2 Slice Controller

This block manages one local slice of a distributed L2 cache. The slice holds two kinds of line. The first is the lines whose home is this slice. The second is replicas of remote-homed lines that the local L1 has just evicted. When the L1 evicts a line whose home is elsewhere, the controller keeps a copy in the local slice. A later L1 miss to that line is then served locally in one cycle, without a trip across the interconnect. A replica never takes the place of a home line that other cores are actively sharing. Inserting a replica produces no traffic toward the directory, so the core still counts as a sharer of the line.

Every L1 miss is looked up in the local slice first. Only a local miss produces a request on the remote port, addressed to the line's home slice. The remote request port uses valid/ready. The request stays valid, with its address held stable, until ready is seen. Only one miss may be outstanding at a time: the miss port drops its ready until the remote response has been returned. The L1 eviction port and the home-install port are also valid/ready. Their ready goes low only while a higher-priority operation takes the slice array in that cycle. The response output is a one-cycle pulse that the L1 always accepts. Invalidations are plain one-cycle pulses and are never refused.

Addresses are line addresses. The low `SET_W` bits select the set. The next `SLICE_W` bits name the home slice. All bits above the set index form the stored tag.

Top module: `vr_slice_ctrl`

## Requirements
- R1: The home slice of an address is the field `addr[SET_W +: SLICE_W]`. A remote request carries that field on `rem_req_home`, and `rem_req_addr` carries the full miss address.
- R2: An accepted L1 eviction of a remote-homed address that is not already in the slice installs it as a replica. A later miss to it raises `resp_valid` with the evicted data, and a one-cycle `replica_hit` pulse, in the cycle after the miss is accepted. No remote request is issued.
- R3: The way a replica replaces is chosen by class. An invalid way goes first, then a replica, then a home line with no sharers. Within one class, the least recently used way goes first. Installs and local hits make a way most recently used.
- R4: A replica never replaces a home line marked shared. If every way of the set holds a shared home line, the eviction is accepted and dropped.
- R5: A miss is looked up locally first. A remote request is raised in the cycle after acceptance only if the local lookup misses. `miss_ready` stays low from acceptance until the response pulse.
- R6: A remote response arriving while a miss is outstanding produces `resp_valid` with that data in the next cycle, with `replica_hit` low. The fetched line is not written into the slice.
- R7: An invalidation clears a replica of the same address in the slice. It is forwarded on `l1_inv_valid`/`l1_inv_addr` in the next cycle. A home line with that address stays valid.
- R8: Installing a replica raises no request on the remote port.
- R9: A home install of a locally homed address writes the line with class shared or unshared, as `home_wr_shared` gives. A hit on it has `replica_hit` low. A home install of an address homed elsewhere is ignored.
- R10: While `rem_req_valid` is high and `rem_req_ready` is low, the request stays valid with an unchanged address.
- R11: Port priority for the slice array is invalidation, then home install, then eviction, then miss. A lower port's ready is low while a higher port is valid.
- R12: An eviction of an address already held in the slice overwrites that way's data and uses no other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | L1 eviction offered |
| evict_ready | output | 1 | L1 eviction accepted this cycle |
| evict_addr | input | ADDR_W | Evicted line address |
| evict_data | input | DATA_W | Evicted line data |
| home_wr_valid | input | 1 | Home line install or sharer-state update |
| home_wr_ready | output | 1 | Home install accepted |
| home_wr_addr | input | ADDR_W | Home line address |
| home_wr_data | input | DATA_W | Home line data |
| home_wr_shared | input | 1 | 1: line has other sharers |
| inv_valid | input | 1 | Invalidation pulse |
| inv_addr | input | ADDR_W | Invalidated address |
| miss_valid | input | 1 | L1 miss request |
| miss_ready | output | 1 | Miss accepted |
| miss_addr | input | ADDR_W | Miss address |
| resp_valid | output | 1 | Response pulse to L1 |
| resp_data | output | DATA_W | Response data |
| replica_hit | output | 1 | Pulse: response came from a local replica |
| rem_req_valid | output | 1 | Remote request valid |
| rem_req_ready | input | 1 | Remote request accepted |
| rem_req_addr | output | ADDR_W | Remote request address |
| rem_req_home | output | SLICE_W | Target home slice |
| rem_rsp_valid | input | 1 | Remote response valid |
| rem_rsp_data | input | DATA_W | Remote response data |
| l1_inv_valid | output | 1 | Invalidation forwarded to L1 |
| l1_inv_addr | output | ADDR_W | Forwarded invalidation address |

## Verification
The assertions check the following on every cycle:
- no array write turns a shared home way into a replica;
- the remote request stays stable under back-pressure;
- a remote request only ever follows a local lookup miss;
- the miss port stays closed while a request is pending;
- every local hit and every invalidation gets its one-cycle follow-up.

The choice of victim by class and age, the dropping of evictions into fully shared sets, and the fact that remote fills are not installed are visible only as later hit or miss outcomes. The directed scenarios show those behaviours by probing lines after carefully ordered eviction sequences.

// File: rtl/vr_pkg.sv
package vr_pkg;
  // Per-way class tag stored beside the address tag.
  typedef enum logic [1:0] {
    CLS_INV       = 2'd0,
    CLS_HOME_UNSH = 2'd1,
    CLS_HOME_SH   = 2'd2,
    CLS_REPLICA   = 2'd3
  } line_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } miss_st_e;
endpackage

// File: rtl/vr_tag_match.sv
module vr_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 14,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
  input  logic [WAYS-1:0][1:0]       row_cls,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (row_cls[w] != vr_pkg::CLS_INV) && (row_tags[w] == tag);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/vr_victim_pick.sv
module vr_victim_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][1:0]       row_cls,
  input  logic [WAYS-1:0][WAY_W-1:0] row_age,
  input  logic                       allow_shared,
  output logic                       found,
  output logic [WAY_W-1:0]           way
);
  import vr_pkg::*;

  // Lower rank is replaced first; rank 4 marks a way that may not be taken.
  function automatic logic [2:0] cls_rank(input logic [1:0] c, input logic sh_ok);
    case (c)
      CLS_INV:       cls_rank = 3'd0;
      CLS_REPLICA:   cls_rank = 3'd1;
      CLS_HOME_UNSH: cls_rank = 3'd2;
      default:       cls_rank = sh_ok ? 3'd3 : 3'd4;
    endcase
  endfunction

  always_comb begin
    logic [2:0]       best_rank;
    logic [WAY_W-1:0] best_age;
    logic [2:0]       r;
    found     = 1'b0;
    way       = '0;
    best_rank = 3'd4;
    best_age  = '0;
    for (int w = 0; w < WAYS; w++) begin
      r = cls_rank(row_cls[w], allow_shared);
      if (r != 3'd4 && (!found || r < best_rank ||
                        (r == best_rank && row_age[w] > best_age))) begin
        found     = 1'b1;
        way       = WAY_W'(w);
        best_rank = r;
        best_age  = row_age[w];
      end
    end
  end
endmodule

// File: rtl/vr_lru_touch.sv
module vr_lru_touch #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] ages_in,
  input  logic [WAY_W-1:0]           way,
  output logic [WAYS-1:0][WAY_W-1:0] ages_out
);
  // Ages form a permutation; the touched way becomes 0 (most recent).
  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign ages_out[w] = (WAY_W'(w) == way) ? '0 :
                         (ages_in[w] < ages_in[way]) ? ages_in[w] + WAY_W'(1) :
                         ages_in[w];
  end
endmodule

// File: rtl/vr_slice_ctrl.sv
module vr_slice_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter int SLICE_W  = 2,
  parameter int LOCAL_ID = 0,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evict_valid,
  output logic               evict_ready,
  input  logic [ADDR_W-1:0]  evict_addr,
  input  logic [DATA_W-1:0]  evict_data,
  input  logic               home_wr_valid,
  output logic               home_wr_ready,
  input  logic [ADDR_W-1:0]  home_wr_addr,
  input  logic [DATA_W-1:0]  home_wr_data,
  input  logic               home_wr_shared,
  input  logic               inv_valid,
  input  logic [ADDR_W-1:0]  inv_addr,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [ADDR_W-1:0]  miss_addr,
  output logic               resp_valid,
  output logic [DATA_W-1:0]  resp_data,
  output logic               replica_hit,
  output logic               rem_req_valid,
  input  logic               rem_req_ready,
  output logic [ADDR_W-1:0]  rem_req_addr,
  output logic [SLICE_W-1:0] rem_req_home,
  input  logic               rem_rsp_valid,
  input  logic [DATA_W-1:0]  rem_rsp_data,
  output logic               l1_inv_valid,
  output logic [ADDR_W-1:0]  l1_inv_addr
);
  import vr_pkg::*;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][1:0]        cls_q;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age_q;
  logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data_q;

  miss_st_e          st_q;
  logic [ADDR_W-1:0] req_addr_q;

  // Port arbitration: invalidation > home install > eviction > miss.
  logic op_inv, op_home, op_evict, op_miss;
  assign home_wr_ready = !inv_valid;
  assign evict_ready   = !inv_valid && !home_wr_valid;
  assign miss_ready    = (st_q == ST_IDLE) && !inv_valid && !home_wr_valid && !evict_valid;
  assign op_inv   = inv_valid;
  assign op_home  = home_wr_valid && home_wr_ready;
  assign op_evict = evict_valid && evict_ready;
  assign op_miss  = miss_valid && miss_ready;

  logic [ADDR_W-1:0]  a_addr;
  logic [SET_W-1:0]   a_set;
  logic [TAG_W-1:0]   a_tag;
  logic               a_local;
  always_comb begin
    if (op_inv)        a_addr = inv_addr;
    else if (op_home)  a_addr = home_wr_addr;
    else if (op_evict) a_addr = evict_addr;
    else               a_addr = miss_addr;
  end
  assign a_set   = a_addr[SET_W-1:0];
  assign a_tag   = a_addr[ADDR_W-1:SET_W];
  assign a_local = (a_addr[SET_W +: SLICE_W] == SLICE_W'(LOCAL_ID));

  logic             lookup_hit;
  logic [WAY_W-1:0] hit_way;
  logic             v_found;
  logic [WAY_W-1:0] v_way;
  logic [WAYS-1:0][WAY_W-1:0] ages_next;
  logic [WAY_W-1:0] touch_way;

  vr_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .row_tags (tag_q[a_set]),
    .row_cls  (cls_q[a_set]),
    .tag      (a_tag),
    .hit      (lookup_hit),
    .hit_way  (hit_way)
  );

  vr_victim_pick #(.WAYS(WAYS)) u_victim (
    .row_cls      (cls_q[a_set]),
    .row_age      (age_q[a_set]),
    .allow_shared (op_home),
    .found        (v_found),
    .way          (v_way)
  );

  vr_lru_touch #(.WAYS(WAYS)) u_lru (
    .ages_in  (age_q[a_set]),
    .way      (touch_way),
    .ages_out (ages_next)
  );

  // Array write decision.
  logic              wr_en, wr_tag_en, wr_data_en, touch_en;
  logic [WAY_W-1:0]  wr_way;
  logic [1:0]        wr_cls;
  logic [1:0]        old_cls;
  logic [1:0]        hit_cls;
  logic [DATA_W-1:0] wr_data;

  assign hit_cls = cls_q[a_set][hit_way];
  assign wr_data = op_home ? home_wr_data : evict_data;

  always_comb begin
    wr_en      = 1'b0;
    wr_tag_en  = 1'b0;
    wr_data_en = 1'b0;
    touch_en   = 1'b0;
    wr_way     = hit_way;
    wr_cls     = hit_cls;
    if (op_inv) begin
      if (lookup_hit && hit_cls == CLS_REPLICA) begin
        wr_en  = 1'b1;
        wr_cls = CLS_INV;
      end
    end else if (op_home) begin
      if (a_local) begin
        wr_en      = 1'b1;
        wr_tag_en  = 1'b1;
        wr_data_en = 1'b1;
        touch_en   = 1'b1;
        wr_way     = lookup_hit ? hit_way : v_way;
        wr_cls     = home_wr_shared ? CLS_HOME_SH : CLS_HOME_UNSH;
      end
    end else if (op_evict) begin
      if (lookup_hit) begin
        wr_en      = 1'b1;
        wr_data_en = 1'b1;
        touch_en   = 1'b1;
      end else if (!a_local && v_found) begin
        wr_en      = 1'b1;
        wr_tag_en  = 1'b1;
        wr_data_en = 1'b1;
        touch_en   = 1'b1;
        wr_way     = v_way;
        wr_cls     = CLS_REPLICA;
      end
    end else if (op_miss && lookup_hit) begin
      touch_en = 1'b1;
    end
  end

  assign old_cls   = cls_q[a_set][wr_way];
  assign touch_way = wr_en ? wr_way : hit_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          cls_q[s][w] <= CLS_INV;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (wr_en) cls_q[a_set][wr_way] <= wr_cls;
      if (touch_en) age_q[a_set] <= ages_next;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en)  tag_q[a_set][wr_way]  <= a_tag;
    if (wr_en && wr_data_en) data_q[a_set][wr_way] <= wr_data;
  end

  // Miss sequencing and responses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      req_addr_q   <= '0;
      resp_valid   <= 1'b0;
      resp_data    <= '0;
      replica_hit  <= 1'b0;
      l1_inv_valid <= 1'b0;
      l1_inv_addr  <= '0;
    end else begin
      resp_valid   <= 1'b0;
      replica_hit  <= 1'b0;
      l1_inv_valid <= inv_valid;
      if (inv_valid) l1_inv_addr <= inv_addr;
      case (st_q)
        ST_IDLE: begin
          if (op_miss) begin
            if (lookup_hit) begin
              resp_valid  <= 1'b1;
              resp_data   <= data_q[a_set][hit_way];
              replica_hit <= (hit_cls == CLS_REPLICA);
            end else begin
              st_q       <= ST_REQ;
              req_addr_q <= miss_addr;
            end
          end
        end
        ST_REQ:  if (rem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (rem_rsp_valid) begin
            resp_valid <= 1'b1;
            resp_data  <= rem_rsp_data;
            st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_req_valid = (st_q == ST_REQ);
  assign rem_req_addr  = req_addr_q;
  assign rem_req_home  = req_addr_q[SET_W +: SLICE_W];
endmodule

// File: rtl/vr_slice_ctrl_chk.sv
module vr_slice_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              rem_req_valid,
  input logic              rem_req_ready,
  input logic [ADDR_W-1:0] rem_req_addr,
  input logic              inv_valid,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              l1_inv_valid,
  input logic [ADDR_W-1:0] l1_inv_addr,
  input logic              resp_valid,
  input logic              replica_hit,
  input logic              wr_en,
  input logic [1:0]        wr_cls,
  input logic [1:0]        old_cls,
  input logic              lookup_hit,
  input logic              op_miss
);
  import vr_pkg::*;

  p_keep_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cls == CLS_REPLICA) |-> (old_cls != CLS_HOME_SH));

  p_single_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req_valid |-> !miss_ready);

  p_local_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rem_req_valid) |-> $past(op_miss && !lookup_hit));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_req_valid && !rem_req_ready) |=> (rem_req_valid && $stable(rem_req_addr)));

  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_miss && lookup_hit) |=> resp_valid);

  p_rep_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    replica_hit |-> resp_valid);

  p_inv_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (l1_inv_valid && l1_inv_addr == $past(inv_addr)));
endmodule

bind vr_slice_ctrl vr_slice_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vr_slice_ctrl_tb_top.sv
module vr_slice_ctrl_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SLICE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic evict_valid = 0, home_wr_valid = 0, home_wr_shared = 0, inv_valid = 0;
  logic miss_valid = 0, rem_req_ready = 0, rem_rsp_valid = 0;
  logic [ADDR_W-1:0] evict_addr = '0, home_wr_addr = '0, inv_addr = '0, miss_addr = '0;
  logic [DATA_W-1:0] evict_data = '0, home_wr_data = '0, rem_rsp_data = '0;
  logic evict_ready, home_wr_ready, miss_ready, resp_valid, replica_hit;
  logic rem_req_valid, l1_inv_valid;
  logic [DATA_W-1:0] resp_data;
  logic [ADDR_W-1:0] rem_req_addr, l1_inv_addr;
  logic [SLICE_W-1:0] rem_req_home;

  vr_slice_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_addr(evict_addr), .evict_data(evict_data),
    .home_wr_valid(home_wr_valid), .home_wr_ready(home_wr_ready),
    .home_wr_addr(home_wr_addr), .home_wr_data(home_wr_data),
    .home_wr_shared(home_wr_shared),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .replica_hit(replica_hit),
    .rem_req_valid(rem_req_valid), .rem_req_ready(rem_req_ready),
    .rem_req_addr(rem_req_addr), .rem_req_home(rem_req_home),
    .rem_rsp_valid(rem_rsp_valid), .rem_rsp_data(rem_rsp_data),
    .l1_inv_valid(l1_inv_valid), .l1_inv_addr(l1_inv_addr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Line address: upper tag bits, home slice field, set index. Local slice is 0.
  function automatic logic [ADDR_W-1:0] mk(input int up, input int home, input int set);
    return {12'(up), 2'(home), 2'(set)};
  endfunction

  task automatic do_evict(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    evict_valid = 1; evict_addr = a; evict_data = d;
    @(posedge clk); #1;
    evict_valid = 0;
    check(rem_req_valid == 0, "R8", "no remote traffic on eviction", rem_req_valid, 0);
  endtask

  task automatic do_home(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit sh);
    @(negedge clk);
    home_wr_valid = 1; home_wr_addr = a; home_wr_data = d; home_wr_shared = sh;
    @(posedge clk); #1;
    home_wr_valid = 0;
  endtask

  task automatic do_inv(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(posedge clk); #1;
    inv_valid = 0;
    check(l1_inv_valid == 1 && l1_inv_addr == a, req, "forward to L1", l1_inv_addr, a);
  endtask

  // Probe: expect a local hit (data, replica flag) or a remote fetch.
  task automatic probe(input logic [ADDR_W-1:0] a, input bit exp_hit,
                       input logic [DATA_W-1:0] exp_d, input bit exp_rep, input string req);
    @(negedge clk);
    miss_valid = 1; miss_addr = a;
    #1;
    check(miss_ready == 1, "R5", "miss_ready when idle", miss_ready, 1);
    @(posedge clk); #1;
    miss_valid = 0;
    if (exp_hit) begin
      check(resp_valid == 1, req, "local hit resp_valid", resp_valid, 1);
      check(resp_data == exp_d, req, "local hit data", resp_data, exp_d);
      check(replica_hit == exp_rep, req, "replica_hit", replica_hit, exp_rep);
      check(rem_req_valid == 0, req, "no remote request on hit", rem_req_valid, 0);
    end else begin
      check(resp_valid == 0 && rem_req_valid == 1, req, "remote request after local miss",
            rem_req_valid, 1);
      check(rem_req_addr == a, "R1", "remote address", rem_req_addr, a);
      check(rem_req_home == a[3:2], "R1", "home slice field", rem_req_home, a[3:2]);
      check(miss_ready == 0, "R5", "miss port closed", miss_ready, 0);
      @(posedge clk); #1;
      check(rem_req_valid == 1 && rem_req_addr == a, "R10", "held under back-pressure",
            rem_req_addr, a);
      @(negedge clk); rem_req_ready = 1;
      @(posedge clk); #1; rem_req_ready = 0;
      check(rem_req_valid == 0, "R10", "request drops after ready", rem_req_valid, 0);
      @(negedge clk); rem_rsp_valid = 1; rem_rsp_data = 32'hF00D_0000 | 32'(a);
      @(posedge clk); #1; rem_rsp_valid = 0;
      check(resp_valid == 1 && resp_data == (32'hF00D_0000 | 32'(a)), "R6", "remote data",
            resp_data, 32'hF00D_0000 | 32'(a));
      check(replica_hit == 0, "R6", "no replica flag on remote", replica_hit, 0);
      check(miss_ready == 1, "R5", "miss port reopens", miss_ready, 1);
    end
  endtask

  task automatic t_reset;
    check(miss_ready == 1, "R5", "reset miss_ready", miss_ready, 1);
    check(resp_valid == 0 && rem_req_valid == 0 && l1_inv_valid == 0, "R5",
          "reset outputs idle", {resp_valid, rem_req_valid, l1_inv_valid}, 0);
  endtask

  task automatic t_replica_basic;
    do_evict(mk(5, 1, 0), 32'hA000_0001);
    probe(mk(5, 1, 0), 1, 32'hA000_0001, 1, "R2");
    probe(mk(9, 3, 0), 0, 0, 0, "R5");
    probe(mk(9, 3, 0), 0, 0, 0, "R6");   // fetched line was not installed
  endtask

  task automatic t_home_and_inv;
    do_home(mk(7, 0, 0), 32'hB000_0007, 0);
    probe(mk(7, 0, 0), 1, 32'hB000_0007, 0, "R9");
    do_home(mk(8, 2, 0), 32'hB000_0008, 0);   // not homed here: ignored
    probe(mk(8, 2, 0), 0, 0, 0, "R9");
    do_inv(mk(5, 1, 0), "R7");
    probe(mk(5, 1, 0), 0, 0, 0, "R7");
    do_inv(mk(7, 0, 0), "R7");
    probe(mk(7, 0, 0), 1, 32'hB000_0007, 0, "R7");
  endtask

  task automatic t_lru;
    for (int i = 0; i < 4; i++) do_evict(mk(16 + i, 1, 1), 32'hC000_0000 + 32'(i));
    probe(mk(16, 1, 1), 1, 32'hC000_0000, 1, "R3");
    do_evict(mk(20, 2, 1), 32'hC000_0004);
    probe(mk(17, 1, 1), 0, 0, 0, "R3");      // least recent replica displaced
    probe(mk(16, 1, 1), 1, 32'hC000_0000, 1, "R3");
    probe(mk(20, 2, 1), 1, 32'hC000_0004, 1, "R3");
  endtask

  task automatic t_class_order;
    do_home(mk(30, 0, 2), 32'hD000_0030, 0);
    do_evict(mk(31, 1, 2), 32'hD000_0031);
    do_evict(mk(32, 1, 2), 32'hD000_0032);
    do_evict(mk(33, 1, 2), 32'hD000_0033);   // takes the last invalid way
    probe(mk(30, 0, 2), 1, 32'hD000_0030, 0, "R3");
    do_evict(mk(34, 3, 2), 32'hD000_0034);   // replica beats unshared home
    probe(mk(31, 1, 2), 0, 0, 0, "R3");
    probe(mk(30, 0, 2), 1, 32'hD000_0030, 0, "R3");
    probe(mk(34, 3, 2), 1, 32'hD000_0034, 1, "R3");
    // set 3: three shared homes and one unshared home
    do_home(mk(40, 0, 3), 32'hE000_0040, 1);
    do_home(mk(41, 0, 3), 32'hE000_0041, 1);
    do_home(mk(42, 0, 3), 32'hE000_0042, 1);
    do_home(mk(43, 0, 3), 32'hE000_0043, 0);
    do_evict(mk(44, 1, 3), 32'hE000_0044);
    probe(mk(43, 0, 3), 0, 0, 0, "R3");      // unshared home displaced
    probe(mk(44, 1, 3), 1, 32'hE000_0044, 1, "R3");
    probe(mk(40, 0, 3), 1, 32'hE000_0040, 0, "R4");
  endtask

  task automatic t_all_shared;
    for (int i = 0; i < 4; i++) do_home(mk(50 + i, 0, 0), 32'hF100_0000 + 32'(i), 1);
    do_evict(mk(60, 2, 0), 32'hF100_0060);
    probe(mk(60, 2, 0), 0, 0, 0, "R4");      // eviction dropped
    for (int i = 0; i < 4; i++) probe(mk(50 + i, 0, 0), 1, 32'hF100_0000 + 32'(i), 0, "R4");
  endtask

  task automatic t_update;
    do_evict(mk(18, 1, 1), 32'h1234_5678);   // already present: overwrite in place
    probe(mk(18, 1, 1), 1, 32'h1234_5678, 1, "R12");
    probe(mk(16, 1, 1), 1, 32'hC000_0000, 1, "R12");
    probe(mk(19, 1, 1), 1, 32'hC000_0003, 1, "R12");
    probe(mk(20, 2, 1), 1, 32'hC000_0004, 1, "R12");
  endtask

  task automatic t_priority;
    @(negedge clk);
    inv_valid = 1; inv_addr = mk(99, 1, 2);
    evict_valid = 1; evict_addr = mk(70, 1, 2); evict_data = 32'h7;
    home_wr_valid = 1; home_wr_addr = mk(71, 0, 2); home_wr_data = 32'h8; home_wr_shared = 0;
    miss_valid = 1; miss_addr = mk(72, 1, 2);
    #1;
    check(home_wr_ready == 0 && evict_ready == 0 && miss_ready == 0, "R11",
          "all lower ports held by invalidation", {home_wr_ready, evict_ready, miss_ready}, 0);
    inv_valid = 0; #1;
    check(home_wr_ready == 1 && evict_ready == 0 && miss_ready == 0, "R11",
          "home install over eviction and miss", {home_wr_ready, evict_ready, miss_ready}, 4);
    home_wr_valid = 0; #1;
    check(evict_ready == 1 && miss_ready == 0, "R11", "eviction over miss",
          {evict_ready, miss_ready}, 2);
    evict_valid = 0; miss_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1;
    t_replica_basic();
    t_home_and_inv();
    t_lru();
    t_class_order();
    t_all_shared();
    t_update();
    t_priority();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule